// File: doc/BRIEF.md
# Load-Store Address Generator

This unit produces the effective memory address and the base-register update for single-register load and store instructions. Each transaction brings four things: the 32-bit instruction word, the value of the base register, the value of the offset register and the current carry flag. The unit decodes the offset from the instruction word. For word and byte transfers the offset is either a 12-bit immediate or the offset register put through a shift. For halfword transfers it is either a split 8-bit immediate or the offset register unshifted. The offset is then added to or subtracted from the base. The indexing bits decide whether the memory access uses the adjusted value or the raw base, and whether the base is rewritten.

Transactions enter and leave through valid/ready handshakes. A word is taken when `in_valid` and `in_ready` are both high on a rising clock edge. A result leaves when `out_valid` and `out_ready` are both high. The default build has one register stage: a word accepted on one edge is offered on `out_valid` from the next edge. While `out_valid` is high and `out_ready` is low, the result stays frozen and no new word is accepted. A producer may drop `in_valid` between words. The memory access, the extension of loaded data and multi-register transfers are handled elsewhere.

Top module: `lsag_unit`

## Requirements
- R1: While `rst_n` is low on a clock edge, and just after it, `out_valid` is 0 and `in_ready` is 1.
- R2: When instruction bit 26 is 1 (word/byte form) and bit 25 is 0, the offset is instruction bits 11:0, zero-extended and not shifted.
- R3: When bit 26 is 1 and bit 25 is 1, the offset register is shifted by the amount in bits 11:7. The kind of shift is set by bits 6:5: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right. A left shift by 0 leaves the value unchanged.
- R4: A logical-right shift with amount 0 acts as a shift by 32 and gives 0. An arithmetic-right shift with amount 0 gives 32 copies of the offset register's bit 31.
- R5: A rotate with amount 0 gives the carry input in bit 31 and offset register bits 31:1 in bits 30:0.
- R6: Bit 23 set adds the offset to the base; bit 23 clear subtracts it. All arithmetic wraps modulo 2^32.
- R7: With bit 24 set (pre-indexed), `out_addr` is the adjusted base. `out_wb_en` equals bit 21, and `out_wb_data` is the adjusted base.
- R8: With bit 24 clear (post-indexed), `out_addr` is the unmodified base. `out_wb_en` is 1 and `out_wb_data` is the adjusted base.
- R9: When bit 26 is 0 (halfword form), bit 22 set selects the offset {bits 11:8, bits 3:0}, zero-extended. Bit 22 clear selects the offset register unshifted.
- R10: A word/byte register-offset word (bit 26 = 1, bit 25 = 1) with bit 4 set raises `out_undef`, and then `out_wb_en` is 0. Every other word gives `out_undef` = 0.
- R11: `in_ready` equals NOT `out_valid` OR `out_ready`. An accepted word appears on the outputs one cycle later. While `out_valid` is high and `out_ready` is low, all outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request word is presented |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_insn | input | 32 | Load/store instruction word |
| in_base | input | 32 | Base register value |
| in_ofs_reg | input | 32 | Offset register value |
| in_carry | input | 1 | Current carry flag |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_addr | output | 32 | Effective memory address |
| out_wb_data | output | 32 | Value to write back to the base register |
| out_wb_en | output | 1 | Base register is to be written |
| out_undef | output | 1 | Instruction word is an undefined encoding |

## Verification
The assertions assume that reset is low on the first clock edge. They also assume that the request fields sampled at an accepted edge are the ones the following result belongs to, so they compare the outputs against the inputs of the previous edge only when a handshake took place. The stimulus holds each word, with its base, offset and carry, unchanged until it is accepted. It inserts idle gaps and stretches of back-pressure, and it uses directed words to reach every zero-amount shift, both index modes, both offset directions, the halfword forms and the undefined encoding.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(WORD_W);

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] wb_data;
    logic              wb_en;
    logic              undef;
  } lsag_result_t;
endpackage

// File: rtl/lsag_shifter.sv
module lsag_shifter
  import lsag_pkg::*;
#(
  parameter int unsigned W   = WORD_W,
  parameter int unsigned AMT = SHAMT_W
) (
  input  logic [W-1:0]   val,
  input  shift_kind_e    kind,
  input  logic [AMT-1:0] amt,
  input  logic           carry,
  output logic [W-1:0]   res
);
  logic [2*W-1:0] doubled;
  logic           amt_zero;

  assign doubled  = {val, val} >> amt;
  assign amt_zero = (amt == '0);

  always_comb begin
    unique case (kind)
      SH_LSL: res = val << amt;
      SH_LSR: res = amt_zero ? '0 : (val >> amt);
      SH_ASR: res = amt_zero ? {W{val[W-1]}} : W'($signed(val) >>> amt);
      SH_ROR: res = amt_zero ? {carry, val[W-1:1]} : doubled[W-1:0];
      default: res = val;
    endcase
  end
endmodule

// File: rtl/lsag_offset_sel.sv
module lsag_offset_sel
  import lsag_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [31:0]  insn,
  input  logic [W-1:0] ofs_reg,
  input  logic         carry,
  output logic [W-1:0] offset,
  output logic         undef
);
  localparam int unsigned AMT = $clog2(W);

  logic         word_form;
  logic         reg_form;
  logic         half_imm;
  logic [W-1:0] shifted;

  assign word_form = insn[26];
  assign reg_form  = insn[25];
  assign half_imm  = insn[22];

  lsag_shifter #(.W(W), .AMT(AMT)) u_shift (
    .val  (ofs_reg),
    .kind (shift_kind_e'(insn[6:5])),
    .amt  (insn[7 +: AMT]),
    .carry(carry),
    .res  (shifted)
  );

  always_comb begin
    if (word_form) begin
      offset = reg_form ? shifted : W'(insn[11:0]);
    end else begin
      offset = half_imm ? W'({insn[11:8], insn[3:0]}) : ofs_reg;
    end
  end

  assign undef = word_form & reg_form & insn[4];
endmodule

// File: rtl/lsag_index.sv
module lsag_index
  import lsag_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [31:0]  insn,
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  output logic [W-1:0] addr,
  output logic [W-1:0] wb_data,
  output logic         wb_en
);
  logic         pre;
  logic         up;
  logic [W-1:0] moved;

  assign pre   = insn[24];
  assign up    = insn[23];
  assign moved = up ? (base + offset) : (base - offset);

  assign addr    = pre ? moved : base;
  assign wb_data = moved;
  assign wb_en   = pre ? insn[21] : 1'b1;
endmodule

// File: rtl/lsag_unit.sv
module lsag_unit
  import lsag_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_insn,
  input  logic [WORD_W-1:0] in_base,
  input  logic [WORD_W-1:0] in_ofs_reg,
  input  logic              in_carry,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_addr,
  output logic [WORD_W-1:0] out_wb_data,
  output logic              out_wb_en,
  output logic              out_undef
);
  logic [WORD_W-1:0] offset;
  logic              undef;
  logic [WORD_W-1:0] addr;
  logic [WORD_W-1:0] wb_data;
  logic              wb_en;
  lsag_result_t      res_d;
  lsag_result_t      res_o;

  lsag_offset_sel #(.W(WORD_W)) u_ofs (
    .insn   (in_insn),
    .ofs_reg(in_ofs_reg),
    .carry  (in_carry),
    .offset (offset),
    .undef  (undef)
  );

  lsag_index #(.W(WORD_W)) u_idx (
    .insn   (in_insn),
    .base   (in_base),
    .offset (offset),
    .addr   (addr),
    .wb_data(wb_data),
    .wb_en  (wb_en)
  );

  assign res_d.addr    = addr;
  assign res_d.wb_data = wb_data;
  assign res_d.wb_en   = wb_en & ~undef;
  assign res_d.undef   = undef;

  generate
    if (REG_OUT) begin : g_reg
      logic         valid_q;
      lsag_result_t res_q;

      assign in_ready = ~valid_q | out_ready;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q <= 1'b0;
          res_q   <= '0;
        end else if (in_ready) begin
          valid_q <= in_valid;
          if (in_valid) res_q <= res_d;
        end
      end

      assign out_valid = valid_q;
      assign res_o     = res_q;
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign res_o     = res_d;
    end
  endgenerate

  assign out_addr    = res_o.addr;
  assign out_wb_data = res_o.wb_data;
  assign out_wb_en   = res_o.wb_en;
  assign out_undef   = res_o.undef;
endmodule

// File: rtl/lsag_chk.sv
module lsag_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_insn,
  input logic [31:0] in_base,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_addr,
  input logic [31:0] out_wb_data,
  input logic        out_wb_en,
  input logic        out_undef
);
  logic take;
  logic bad_word;
  assign take     = in_valid & in_ready;
  assign bad_word = in_insn[26] & in_insn[25] & in_insn[4];

  // R10
  undef_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> !out_wb_en);

  generate
    if (REG_OUT) begin : g_seq
      // R1
      reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

      // R11
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
          && $stable(out_wb_data) && $stable(out_wb_en) && $stable(out_undef));

      // R11
      stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

      // R11
      accept_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid);

      // R8
      post_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !in_insn[24] && !bad_word |=> out_wb_en && out_addr == $past(in_base));

      // R7
      pre_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && in_insn[24] && !in_insn[21] |=> !out_wb_en);
    end
  endgenerate
endmodule

bind lsag_unit lsag_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_insn    (in_insn),
  .in_base    (in_base),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_wb_data(out_wb_data),
  .out_wb_en  (out_wb_en),
  .out_undef  (out_undef)
);

// File: tb/lsag_unit_tb.sv
module lsag_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] insn;
    logic [31:0] base;
    logic [31:0] ofs;
    logic        c;
  } stim_t;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wb;
    logic        wen;
    logic        undef;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_base = '0;
  logic [31:0] in_ofs_reg = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [31:0] out_wb_data;
  logic        out_wb_en;
  logic        out_undef;

  int total = 0;
  int bad = 0;

  stim_t stims[$];
  exp_t  expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsag_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_base(in_base), .in_ofs_reg(in_ofs_reg), .in_carry(in_carry),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_wb_data(out_wb_data),
    .out_wb_en(out_wb_en), .out_undef(out_undef)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic exp_t ref_model(input stim_t s);
    exp_t        e;
    logic [31:0] off;
    logic [63:0] wide;
    int          amt;
    int          eff;
    amt = int'(s.insn[11:7]);
    eff = (amt == 0) ? 32 : amt;
    e.tag = "R2";
    if (s.insn[26]) begin
      if (!s.insn[25]) begin
        off = {20'd0, s.insn[11:0]};
      end else begin
        e.tag = "R3";
        case (s.insn[6:5])
          2'd0: off = s.ofs << amt;
          2'd1: begin wide = {32'd0, s.ofs} >> eff; off = wide[31:0];
                  if (amt == 0) e.tag = "R4"; end
          2'd2: begin wide = {{32{s.ofs[31]}}, s.ofs} >> eff; off = wide[31:0];
                  if (amt == 0) e.tag = "R4"; end
          default: begin
            if (amt == 0) begin off = {s.c, s.ofs[31:1]}; e.tag = "R5"; end
            else begin wide = {s.ofs, s.ofs} >> amt; off = wide[31:0]; end
          end
        endcase
      end
    end else begin
      e.tag = "R9";
      off = s.insn[22] ? {24'd0, s.insn[11:8], s.insn[3:0]} : s.ofs;
    end
    e.undef = s.insn[26] && s.insn[25] && s.insn[4];
    e.wb    = s.insn[23] ? s.base + off : s.base + (~off + 32'd1);
    e.addr  = s.insn[24] ? e.wb : s.base;
    e.wen   = e.undef ? 1'b0 : (s.insn[24] ? s.insn[21] : 1'b1);
    e.tag   = {e.tag, " R6"};
    return e;
  endfunction

  function automatic logic [31:0] w_imm(bit p, bit u, bit w, logic [11:0] imm);
    return {4'hE, 2'b01, 1'b0, p, u, 1'b0, w, 1'b1, 4'd1, 4'd2, imm};
  endfunction

  function automatic logic [31:0] w_reg(bit p, bit u, bit w, logic [4:0] amt, logic [1:0] ty, bit b4);
    return {4'hE, 2'b01, 1'b1, p, u, 1'b0, w, 1'b0, 4'd1, 4'd2, amt, ty, b4, 4'd3};
  endfunction

  function automatic logic [31:0] h_form(bit p, bit u, bit imm, bit w, logic [7:0] v);
    return {4'hE, 3'b000, p, u, imm, w, 1'b1, 4'd1, 4'd2, v[7:4], 4'b1011, v[3:0]};
  endfunction

  function automatic stim_t mk(logic [31:0] i, logic [31:0] b, logic [31:0] o, logic c);
    stim_t s;
    s.insn = i; s.base = b; s.ofs = o; s.c = c;
    return s;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    stim_t pend;
    bit    have = 0;
    int    cyc  = 0;
    bit    fire_in, fire_out;
    exp_t  e;

    stims.push_back(mk(w_imm(1,1,0,12'h123), 32'h0000_1000, 32'hDEAD_BEEF, 0));
    stims.push_back(mk(w_imm(1,0,1,12'hFFF), 32'h0000_0100, 32'h0, 0));
    stims.push_back(mk(w_imm(0,1,0,12'h004), 32'h2000_0000, 32'h0, 1));
    stims.push_back(mk(w_reg(1,1,0,5'd3,2'd0,0), 32'h100, 32'h0000_0011, 0));
    stims.push_back(mk(w_reg(1,1,0,5'd0,2'd0,0), 32'h100, 32'h8000_0001, 1));
    stims.push_back(mk(w_reg(1,1,0,5'd4,2'd1,0), 32'h100, 32'hF000_00F0, 0));
    stims.push_back(mk(w_reg(1,1,0,5'd0,2'd1,0), 32'h100, 32'hFFFF_FFFF, 1));
    stims.push_back(mk(w_reg(1,1,0,5'd0,2'd2,0), 32'h100, 32'h8000_0000, 0));
    stims.push_back(mk(w_reg(1,1,0,5'd0,2'd2,0), 32'h100, 32'h7FFF_FFFF, 1));
    stims.push_back(mk(w_reg(1,0,1,5'd7,2'd2,0), 32'h100, 32'h8000_0F00, 0));
    stims.push_back(mk(w_reg(1,1,0,5'd8,2'd3,0), 32'h0, 32'h1234_5678, 0));
    stims.push_back(mk(w_reg(1,1,0,5'd0,2'd3,0), 32'h0, 32'h0000_0003, 1));
    stims.push_back(mk(w_reg(1,1,0,5'd0,2'd3,0), 32'h0, 32'h0000_0003, 0));
    stims.push_back(mk(w_reg(0,0,1,5'd2,2'd0,0), 32'h400, 32'h10, 0));
    stims.push_back(mk(h_form(1,1,1,0,8'hA5), 32'h1000, 32'hFFFF, 0));
    stims.push_back(mk(h_form(0,0,0,0,8'h00), 32'h1000, 32'h0000_0020, 0));
    stims.push_back(mk(w_reg(1,1,1,5'd1,2'd0,1), 32'h1000, 32'h4, 0));
    for (int k = 0; k < 400; k++)
      stims.push_back(mk($urandom, $urandom, $urandom, 1'($urandom)));

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    while (stims.size() != 0 || have || expq.size() != 0) begin
      @(negedge clk);
      cyc++;
      if (!have && stims.size() != 0 && ($urandom % 5 != 0)) begin
        pend = stims.pop_front();
        have = 1;
      end
      in_valid   = have;
      in_insn    = have ? pend.insn : $urandom;
      in_base    = have ? pend.base : $urandom;
      in_ofs_reg = have ? pend.ofs  : $urandom;
      in_carry   = have ? pend.c    : 1'($urandom);
      out_ready  = (cyc < 40) ? 1'b1 : ($urandom % 10 < 7);
      #1;
      // R11: valid tracks the model occupancy, ready follows the rule
      check("R11 out_valid", {31'd0, out_valid}, {31'd0, expq.size() != 0});
      check("R11 in_ready", {31'd0, in_ready}, {31'd0, (expq.size() == 0) || out_ready});
      fire_out = out_valid && out_ready;
      fire_in  = in_valid && in_ready;
      if (fire_out && expq.size() != 0) begin
        e = expq.pop_front();
        if (e.undef) begin
          check("R10 undef", {31'd0, out_undef}, 32'd1);
          check("R10 wb_en", {31'd0, out_wb_en}, 32'd0);
        end else begin
          check("R10 undef clear", {31'd0, out_undef}, 32'd0);
          check({e.tag, " addr"}, out_addr, e.addr);
          check({e.tag, " wb_data"}, out_wb_data, e.wb);
          check("R7 R8 wb_en", {31'd0, out_wb_en}, {31'd0, e.wen});
        end
      end
      if (fire_in) begin
        expq.push_back(ref_model(pend));
        have = 0;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule